// File: doc/BRIEF.md
# Random Command Handler with Nonce Synchronisation

This block runs the "random" command of a secure-memory controller. A command front end hands it an already parsed command: opcode, mode byte, two 16-bit parameter words and a data byte count. The handler validates the fields. It refreshes the persistent generator seed when the mode asks for a refresh and the seed has not yet been refreshed in the current epoch. It then produces 16 bytes and returns them behind a one-byte status over a byte-wide valid/ready response channel.

The returned bytes depend on the configuration lock byte. When the lock byte reads as unlocked, every byte is a fixed test pattern. In every other case the bytes come from a 32-bit LFSR, which stands in for a real generator. One mode bit can also load the first twelve bytes into a nonce register and update three nonce status flags. An epoch is the span between two reset-type events: power-on, wake from sleep, a reset command or a tamper event. Any of these events re-arms the seed refresh.

Top module: `rand_cmd_unit`

## Requirements
- R1: After reset, busy_o, rsp_valid_o, seed_wr_o and the three nonce flags are 0, nonce_o is 0, and cmd_ready_o is 1.
- R2: A command is valid only when all of these hold: opcode 0x02, param words both 0x0000, data count 0, and mode bits 0 and 3..7 all zero (mode & 0xF9 == 0). Otherwise the response is a single status byte 0x01 with rsp_last_o set. In that case there is no seed request, and the nonce register and flags stay unchanged.
- R3: A valid command returns status byte 0x00 followed by 16 data bytes in generation order. rsp_last_o is set on the 17th byte only.
- R4: When cfg_lock_i equals 0x55 at acceptance, all 16 data bytes are 0xA5 and the LFSR does not advance.
- R5: For any other lock value, the LFSR advances once per data byte and each byte is the low byte of the new state. The LFSR is a right-shifting Galois LFSR: next = (s >> 1) ^ (s[0] ? 0xA3000000 : 0). Its reset state is 0x1ACEB00C.
- R6: With mode bit 2 = 0, nonce_o and the nonce flags are left unchanged.
- R7: With mode bit 2 = 1, nonce_o takes the first 12 data bytes, the first byte in bits 95:88. nonce_valid_o = 1, nonce_random_o = 0 and nonce_compute_o = 1 are set before the status byte is offered.
- R8: With mode bit 1 = 0 and the seed not yet refreshed in this epoch, seed_wr_o pulses for exactly one cycle. No response byte is offered until seed_done_i arrives. On seed_done_i the LFSR state becomes rotl1(s) ^ 0x5A5A0F0F.
- R9: In one epoch, at most one seed request is made. A command with mode bit 1 = 1 never makes one.
- R10: A pulse on any bit of evt_i (power-on, wake, reset command, tamper) starts a new epoch, so the next command with mode bit 1 = 0 requests a refresh again.
- R11: busy_o rises on the edge that accepts a command and falls on the edge that takes the last response byte. cmd_ready_o is low and commands offered meanwhile are ignored.
- R12: While rsp_valid_o is high and rsp_ready_i is low, rsp_data_o and rsp_last_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Parsed command present |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_opcode_i | input | 8 | Command opcode |
| cmd_mode_i | input | 8 | Mode byte |
| cmd_param1_i | input | 16 | First parameter word |
| cmd_param2_i | input | 16 | Second parameter word |
| cmd_dlen_i | input | 8 | Number of data bytes carried |
| cfg_lock_i | input | 8 | Configuration lock byte |
| evt_i | input | 4 | Reset-type events: power-on, wake, reset command, tamper |
| seed_wr_o | output | 1 | One-cycle seed write request |
| seed_done_i | input | 1 | Seed write completed |
| rsp_valid_o | output | 1 | Response byte valid |
| rsp_ready_i | input | 1 | Response byte taken |
| rsp_data_o | output | 8 | Response byte |
| rsp_last_o | output | 1 | Final response byte |
| busy_o | output | 1 | Command in progress |
| nonce_o | output | 96 | Nonce register |
| nonce_valid_o | output | 1 | Nonce holds a value |
| nonce_random_o | output | 1 | Nonce is random (0 = fixed) |
| nonce_compute_o | output | 1 | Nonce is ready for the compute step |

## Verification
A rejected command offers its status byte on the edge that accepts it. A valid command that needs no seed refresh offers its status byte 16 edges after acceptance, one edge per generated byte. The bench counts edges from the accept edge and compares the count against 0 or 16. When a seed refresh is pending, the bench checks only that the seed completion arrived before the first byte. The bench drives inputs and samples outputs at the falling edge. It compares nonce and flags only after the last byte is taken, and it checks that busy and valid are low one and two cycles later.

// File: rtl/rand_cmd_pkg.sv
package rand_cmd_pkg;
  localparam logic [7:0] OPC_RANDOM     = 8'h02;
  localparam logic [7:0] LOCK_OPEN      = 8'h55;
  localparam logic [7:0] TEST_BYTE      = 8'hA5;
  localparam logic [7:0] ST_OK          = 8'h00;
  localparam logic [7:0] ST_PARAM_ERR   = 8'h01;
  localparam logic [7:0] MODE_RSVD_MASK = 8'hF9;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEED_REQ,
    S_SEED_WAIT,
    S_GEN,
    S_RESP
  } rc_state_e;
endpackage

// File: rtl/rand_entropy.sv
module rand_entropy #(
  parameter int              W         = 32,
  parameter logic [W-1:0]    POLY      = 32'hA300_0000,
  parameter logic [W-1:0]    SEED_INIT = 32'h1ACE_B00C,
  parameter logic [W-1:0]    SEED_MIX  = 32'h5A5A_0F0F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       mix_i,
  input  logic       test_i,
  output logic [7:0] byte_o
);
  import rand_cmd_pkg::*;

  logic [W-1:0] st_q;
  logic [W-1:0] st_nxt;

  assign st_nxt = {1'b0, st_q[W-1:1]} ^ (st_q[0] ? POLY : '0);
  assign byte_o = test_i ? TEST_BYTE : st_nxt[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               st_q <= SEED_INIT;
    else if (mix_i)            st_q <= {st_q[W-2:0], st_q[W-1]} ^ SEED_MIX;
    else if (step_i && !test_i) st_q <= st_nxt;
  end
endmodule

// File: rtl/rand_seed_epoch.sv
module rand_seed_epoch #(
  parameter int N_EVT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             set_i,
  output logic             seeded_o
);
  // event wins over a same-cycle refresh: the new epoch stays unrefreshed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seeded_o <= 1'b0;
    else if (|evt_i) seeded_o <= 1'b0;
    else if (set_i)  seeded_o <= 1'b1;
  end
endmodule

// File: rtl/rand_cmd_unit.sv
module rand_cmd_unit #(
  parameter int          N_BYTES     = 16,
  parameter int          NONCE_BYTES = 12,
  parameter int          N_EVT       = 4,
  parameter int          ENT_W       = 32,
  parameter logic [31:0] ENT_POLY    = 32'hA300_0000,
  parameter logic [31:0] SEED_INIT   = 32'h1ACE_B00C,
  parameter logic [31:0] SEED_MIX    = 32'h5A5A_0F0F,
  localparam int         NONCE_W     = NONCE_BYTES * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [7:0]         cmd_opcode_i,
  input  logic [7:0]         cmd_mode_i,
  input  logic [15:0]        cmd_param1_i,
  input  logic [15:0]        cmd_param2_i,
  input  logic [7:0]         cmd_dlen_i,
  input  logic [7:0]         cfg_lock_i,
  input  logic [N_EVT-1:0]   evt_i,
  output logic               seed_wr_o,
  input  logic               seed_done_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [7:0]         rsp_data_o,
  output logic               rsp_last_o,
  output logic               busy_o,
  output logic [NONCE_W-1:0] nonce_o,
  output logic               nonce_valid_o,
  output logic               nonce_random_o,
  output logic               nonce_compute_o
);
  import rand_cmd_pkg::*;

  localparam int BUF_W = N_BYTES * 8;
  localparam int CNT_W = $clog2(N_BYTES);
  localparam int IDX_W = $clog2(N_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_BYTES);

  rc_state_e          state_q;
  logic               err_q, store_q, test_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [BUF_W-1:0]   buf_q;
  logic [BUF_W-1:0]   buf_nxt;
  logic [7:0]         ent_byte;
  logic               seeded;
  logic               cmd_ok;

  assign cmd_ok = (cmd_opcode_i == OPC_RANDOM) && ((cmd_mode_i & MODE_RSVD_MASK) == 8'h00)
               && (cmd_param1_i == 16'h0000) && (cmd_param2_i == 16'h0000)
               && (cmd_dlen_i == 8'h00);

  assign busy_o      = (state_q != S_IDLE);
  assign cmd_ready_o = !busy_o;
  assign seed_wr_o   = (state_q == S_SEED_REQ);
  assign rsp_valid_o = (state_q == S_RESP);
  assign rsp_last_o  = rsp_valid_o && (err_q ? (idx_q == '0) : (idx_q == IDX_LAST));
  assign rsp_data_o  = (idx_q == '0) ? (err_q ? ST_PARAM_ERR : ST_OK) : buf_q[BUF_W-1 -: 8];
  assign buf_nxt     = {buf_q[BUF_W-9:0], ent_byte};

  rand_entropy #(
    .W(ENT_W), .POLY(ENT_POLY), .SEED_INIT(SEED_INIT), .SEED_MIX(SEED_MIX)
  ) u_ent (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (state_q == S_GEN),
    .mix_i  ((state_q == S_SEED_WAIT) && seed_done_i),
    .test_i (test_q),
    .byte_o (ent_byte)
  );

  rand_seed_epoch #(.N_EVT(N_EVT)) u_epoch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .set_i    (seed_wr_o),
    .seeded_o (seeded)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= S_IDLE;
      err_q           <= 1'b0;
      store_q         <= 1'b0;
      test_q          <= 1'b0;
      cnt_q           <= '0;
      idx_q           <= '0;
      buf_q           <= '0;
      nonce_o         <= '0;
      nonce_valid_o   <= 1'b0;
      nonce_random_o  <= 1'b0;
      nonce_compute_o <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          err_q   <= !cmd_ok;
          store_q <= cmd_mode_i[2];
          test_q  <= (cfg_lock_i == LOCK_OPEN);
          cnt_q   <= '0;
          idx_q   <= '0;
          if (!cmd_ok)                           state_q <= S_RESP;
          else if (!cmd_mode_i[1] && !seeded)    state_q <= S_SEED_REQ;
          else                                   state_q <= S_GEN;
        end
        S_SEED_REQ:  state_q <= S_SEED_WAIT;
        S_SEED_WAIT: if (seed_done_i) state_q <= S_GEN;
        S_GEN: begin
          buf_q <= buf_nxt;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_LAST) begin
            state_q <= S_RESP;
            if (store_q) begin
              nonce_o         <= buf_nxt[BUF_W-1 -: NONCE_W];
              nonce_valid_o   <= 1'b1;
              nonce_random_o  <= 1'b0;
              nonce_compute_o <= 1'b1;
            end
          end
        end
        S_RESP: if (rsp_ready_i) begin
          if (rsp_last_o) state_q <= S_IDLE;
          else begin
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q != '0) buf_q <= {buf_q[BUF_W-9:0], 8'h00};
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rand_cmd_unit_chk.sv
module rand_cmd_unit_chk #(
  parameter int N_EVT   = 4,
  parameter int NONCE_W = 96
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_i,
  input logic               cmd_ready_o,
  input logic               busy_o,
  input logic [N_EVT-1:0]   evt_i,
  input logic               seed_wr_o,
  input logic               seed_done_i,
  input logic               rsp_valid_o,
  input logic               rsp_ready_i,
  input logic [7:0]         rsp_data_o,
  input logic               rsp_last_o,
  input logic [NONCE_W-1:0] nonce_o,
  input logic               nonce_valid_o,
  input logic               nonce_random_o,
  input logic               nonce_compute_o
);
  logic ck_seeded, ck_pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ck_seeded <= 1'b0;
    else if (|evt_i)    ck_seeded <= 1'b0;
    else if (seed_wr_o) ck_seeded <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ck_pending <= 1'b0;
    else if (seed_wr_o)   ck_pending <= 1'b1;
    else if (seed_done_i) ck_pending <= 1'b0;
  end

  a_r8_seed_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_wr_o |=> !seed_wr_o);
  a_r8_no_rsp_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_pending |-> !rsp_valid_o);
  a_r9_one_seed_per_epoch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_wr_o |-> !ck_seeded);
  a_r11_ready_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cmd_ready_o);
  a_r11_busy_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> busy_o);
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_last_o)));
  a_r3_last_in_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |-> rsp_valid_o);
  a_r7_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nonce_valid_o) |-> (nonce_compute_o && !nonce_random_o));
  a_r6_nonce_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(nonce_o));
endmodule

bind rand_cmd_unit rand_cmd_unit_chk #(.N_EVT(N_EVT), .NONCE_W(NONCE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .busy_o(busy_o), .evt_i(evt_i), .seed_wr_o(seed_wr_o), .seed_done_i(seed_done_i),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_data_o(rsp_data_o),
  .rsp_last_o(rsp_last_o), .nonce_o(nonce_o), .nonce_valid_o(nonce_valid_o),
  .nonce_random_o(nonce_random_o), .nonce_compute_o(nonce_compute_o)
);

// File: tb/rand_cmd_unit_tb.sv
module rand_cmd_unit_tb;
  localparam logic [31:0] POLY      = 32'hA300_0000;
  localparam logic [31:0] SEED_INIT = 32'h1ACE_B00C;
  localparam logic [31:0] SEED_MIX  = 32'h5A5A_0F0F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [7:0]  cmd_opcode_i = '0, cmd_mode_i = '0, cmd_dlen_i = '0, cfg_lock_i = 8'h55;
  logic [15:0] cmd_param1_i = '0, cmd_param2_i = '0;
  logic [3:0]  evt_i = '0;
  logic        seed_wr_o, seed_done_i = 1'b0;
  logic        rsp_valid_o, rsp_ready_i = 1'b0, rsp_last_o, busy_o;
  logic [7:0]  rsp_data_o;
  logic [95:0] nonce_o;
  logic        nonce_valid_o, nonce_random_o, nonce_compute_o;

  int checks = 0, fails = 0, seed_reqs = 0, seed_dones = 0;
  bit finished = 0;

  logic [31:0] m_st = SEED_INIT;
  bit          m_seeded = 0;
  logic [95:0] m_nonce = '0;
  logic [2:0]  m_flags = '0;  // {valid, random, compute}

  always #4 clk_i = ~clk_i;

  rand_cmd_unit u_dut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_opcode_i, .cmd_mode_i,
    .cmd_param1_i, .cmd_param2_i, .cmd_dlen_i, .cfg_lock_i, .evt_i, .seed_wr_o,
    .seed_done_i, .rsp_valid_o, .rsp_ready_i, .rsp_data_o, .rsp_last_o, .busy_o,
    .nonce_o, .nonce_valid_o, .nonce_random_o, .nonce_compute_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? POLY : 32'h0);
  endfunction

  // seed store model: answers each request after a few cycles
  initial forever begin
    @(negedge clk_i);
    if (seed_wr_o) begin
      seed_reqs++;
      repeat (3) @(negedge clk_i);
      seed_done_i = 1'b1;
      seed_dones++;
      @(negedge clk_i);
      seed_done_i = 1'b0;
    end
  end

  task automatic t_reset();
    chk(busy_o == 0 && rsp_valid_o == 0 && seed_wr_o == 0, "R1", "busy/valid/seed", 
        {busy_o, rsp_valid_o, seed_wr_o}, 0);
    chk(cmd_ready_o == 1, "R1", "cmd_ready", cmd_ready_o, 1);
    chk(nonce_o == 0 && {nonce_valid_o, nonce_random_o, nonce_compute_o} == 0, "R1", "nonce",
        {nonce_valid_o, nonce_random_o, nonce_compute_o, nonce_o}, 0);
  endtask

  task automatic pulse_evt(input logic [3:0] e);
    @(negedge clk_i);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
    m_seeded = 0;
  endtask

  task automatic run_cmd(input logic [7:0] opc, input logic [7:0] mode,
                         input logic [15:0] p1, input logic [15:0] p2, input logic [7:0] dlen,
                         input logic [7:0] lock, input bit bp, input bit poke, input string req);
    bit         err  = !(opc == 8'h02 && (mode & 8'hF9) == 0 && p1 == 0 && p2 == 0 && dlen == 0);
    bit         test = (lock == 8'h55);
    bit         need_seed = !err && !mode[1] && !m_seeded;
    int         exp_len = err ? 1 : 17;
    logic [7:0] exp_b [17];
    logic [7:0] got_b [17];
    int         n = 0, k = 0, guard = 0, req0 = seed_reqs;
    bit         done = 0, stalled = 0, tgl = 0;
    logic [7:0] held = '0;

    exp_b[0] = err ? 8'h01 : 8'h00;
    if (need_seed) begin
      m_st = {m_st[30:0], m_st[31]} ^ SEED_MIX;
      m_seeded = 1;
    end
    for (int i = 1; i < 17; i++) begin
      if (err) exp_b[i] = 8'h00;
      else if (test) exp_b[i] = 8'hA5;
      else begin
        m_st = lfsr_step(m_st);
        exp_b[i] = m_st[7:0];
      end
    end
    if (!err && mode[2]) begin
      for (int i = 0; i < 12; i++) m_nonce[95 - 8*i -: 8] = exp_b[i+1];
      m_flags = 3'b101;
    end

    @(negedge clk_i);
    cmd_opcode_i = opc; cmd_mode_i = mode; cmd_param1_i = p1; cmd_param2_i = p2;
    cmd_dlen_i = dlen; cfg_lock_i = lock; cmd_valid_i = 1'b1;
    chk(cmd_ready_o == 1, "R11", "ready before accept", cmd_ready_o, 1);
    @(posedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = poke;
    chk(busy_o == 1, "R11", "busy after accept", busy_o, 1);
    while (!rsp_valid_o && n < 400) begin
      if (busy_o !== 1'b1 || cmd_ready_o !== 1'b0) chk(0, "R11", "busy while working", busy_o, 1);
      @(posedge clk_i); @(negedge clk_i); n++;
    end
    if (err)            chk(n == 0,  "R2", "error status latency", n, 0);
    else if (!need_seed) chk(n == 16, "R3", "status latency", n, 16);
    else chk(seed_dones == seed_reqs && seed_reqs == req0 + 1, "R8", "done before response",
             seed_dones, seed_reqs);

    while (!done && guard < 200) begin
      guard++;
      if (stalled) chk(rsp_valid_o && rsp_data_o == held, "R12", "hold under backpressure",
                       rsp_data_o, held);
      tgl = !tgl;
      rsp_ready_i = bp ? tgl : 1'b1;
      stalled = 0;
      if (rsp_valid_o) begin
        if (rsp_ready_i) begin
          if (k < 17) got_b[k] = rsp_data_o;
          chk(rsp_last_o == (k == exp_len - 1), req, "last flag position", k, exp_len - 1);
          if (rsp_last_o) begin done = 1; cmd_valid_i = 1'b0; end
          k++;
        end else begin
          stalled = 1; held = rsp_data_o;
        end
      end
      @(posedge clk_i); @(negedge clk_i);
    end
    rsp_ready_i = 1'b0;
    cmd_valid_i = 1'b0;
    chk(k == exp_len, req, "response length", k, exp_len);
    chk(busy_o == 0 && rsp_valid_o == 0 && cmd_ready_o == 1, "R11", "idle after last",
        {busy_o, rsp_valid_o, cmd_ready_o}, 1);
    @(posedge clk_i); @(negedge clk_i);
    chk(rsp_valid_o == 0 && busy_o == 0, "R11", "offered command ignored", {busy_o, rsp_valid_o}, 0);

    for (int i = 0; i < exp_len && i < k; i++)
      chk(got_b[i] == exp_b[i], (i == 0) ? (err ? "R2" : "R3") : req, "response byte",
          got_b[i], exp_b[i]);
    chk(seed_reqs - req0 == int'(need_seed), need_seed ? "R8" : "R9", "seed request count",
        seed_reqs - req0, need_seed);
    chk(nonce_o == m_nonce, mode[2] && !err ? "R7" : "R6", "nonce register", nonce_o, m_nonce);
    chk({nonce_valid_o, nonce_random_o, nonce_compute_o} == m_flags, mode[2] && !err ? "R7" : "R6",
        "nonce flags", {nonce_valid_o, nonce_random_o, nonce_compute_o}, m_flags);
  endtask

  task automatic t_test_mode();   // R4, R8: unlocked lock returns pattern, first refresh
    run_cmd(8'h02, 8'h00, 16'h0, 16'h0, 8'h0, 8'h55, 0, 0, "R4");
    run_cmd(8'h02, 8'h06, 16'h0, 16'h0, 8'h0, 8'h55, 0, 0, "R4");
  endtask

  task automatic t_random_bp();   // R5, R6, R12, R11 with poke
    run_cmd(8'h02, 8'h02, 16'h0, 16'h0, 8'h0, 8'h00, 1, 1, "R5");
  endtask

  task automatic t_nonce_store(); // R7, R9: refresh already done in epoch
    run_cmd(8'h02, 8'h04, 16'h0, 16'h0, 8'h0, 8'h00, 0, 0, "R7");
  endtask

  task automatic t_errors();      // R2 after new epoch: errors must not request seed
    run_cmd(8'h03, 8'h00, 16'h0, 16'h0, 8'h0, 8'h00, 0, 0, "R2");
    run_cmd(8'h02, 8'h05, 16'h0, 16'h0, 8'h0, 8'h00, 0, 0, "R2");
    run_cmd(8'h02, 8'h80, 16'h0, 16'h0, 8'h0, 8'h00, 0, 0, "R2");
    run_cmd(8'h02, 8'h00, 16'h1, 16'h0, 8'h0, 8'h00, 1, 0, "R2");
    run_cmd(8'h02, 8'h00, 16'h0, 16'h8000, 8'h0, 8'h00, 0, 0, "R2");
    run_cmd(8'h02, 8'h00, 16'h0, 16'h0, 8'h1, 8'h00, 0, 0, "R2");
  endtask

  task automatic t_new_epoch();   // R10 then R9, other lock value R5
    run_cmd(8'h02, 8'h00, 16'h0, 16'h0, 8'h0, 8'h3C, 0, 0, "R10");
    run_cmd(8'h02, 8'h04, 16'h0, 16'h0, 8'h0, 8'h3C, 1, 0, "R9");
    pulse_evt(4'b0010);
    run_cmd(8'h02, 8'h02, 16'h0, 16'h0, 8'h0, 8'h00, 0, 0, "R9");
    run_cmd(8'h02, 8'h00, 16'h0, 16'h0, 8'h0, 8'h00, 0, 0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_test_mode();
    t_random_bp();
    t_nonce_store();
    pulse_evt(4'b1000);
    t_errors();
    t_new_epoch();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule